// File: doc/BRIEF.md
# Clock Driver Divider Output Stage

This block is the digital back end of a zero-delay clock driver. It sits behind the oscillator of a phase-locked loop and turns one internal clock into a set of related output clocks. The outputs are a double-rate clock, several identical base-rate clocks, one base-rate clock of opposite polarity, and a half-rate clock. The rising edges of all of them are aligned. The loop itself (phase detector, filter, oscillator, lock detect) lies outside the block; the oscillator arrives as the `osc_clk` input.

One of two reference clocks is chosen by `ref_pick`. When `osc_en` is low, that reference replaces the oscillator, so the output dividers can be run slowly or stepped for test. When `div_sel` is high, the source passes through an extra halving stage before the dividers, and every output frequency drops by half. A shared down-counter supplies all the divided phases, so the divided outputs have their rising edges on the same source edge.

An active-low asynchronous reset clears every output register. It also drops a per-output enable bit, which stands for a high-impedance pin. The bit pair value/enable lets a chip-level pad ring build the real tri-state driver.

Top module: `clkdrv_outstage`

## Requirements
- R1: In bypass mode (`osc_en`=0), `ref_pick`=1 clocks the stage from `ref_b_clk` and `ref_pick`=0 clocks it from `ref_a_clk`.
- R2: With `osc_en`=1 the stage is clocked from `osc_clk`, and `ref_pick` has no effect on any output frequency.
- R3: With `div_sel`=1 every output runs at half the frequency it has with `div_sel`=0 from the same source.
- R4: With `div_sel`=0, `dbl_val` toggles on every source rising edge. `base_val` runs at one quarter of the source frequency, and `half_val` runs at one eighth. So the ratio of double, base and half frequencies is 2:1:0.5.
- R5: All `NUM_BASE` bits of `base_val` are equal at all times.
- R6: While reset is high, `inv_val` is the complement of `base_val`.
- R7: While `rst_n` is low, the block is cleared asynchronously, without waiting for a clock edge. Then `dbl_val`, `base_val` and `half_val` are 0, `inv_val` is 1, and every enable bit is 0 (high impedance).
- R8: While `rst_n` is high, every enable bit (`dbl_oe`, `base_oe`, `inv_oe`, `half_oe`) is 1.
- R9: Counting from the first source rising edge after reset is released, the vector (`dbl_val`, `base_val[0]`, `half_val`) takes these values on edges 1 to 5:
  - with `div_sel`=0: 111, 011, 101, 001, 110;
  - with `div_sel`=1: 111, 111, 011, 011, 101.
- R10: Every rising edge of `half_val` coincides with rising edges of `base_val` and `dbl_val`. Every rising edge of `base_val` coincides with a rising edge of `dbl_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock from the loop |
| ref_a_clk | input | 1 | First reference clock |
| ref_b_clk | input | 1 | Second reference clock |
| ref_pick | input | 1 | 1 selects `ref_b_clk`, 0 selects `ref_a_clk` |
| osc_en | input | 1 | 1: oscillator drives the stage; 0: selected reference drives it |
| div_sel | input | 1 | 1 inserts a divide-by-two ahead of the output registers |
| rst_n | input | 1 | Asynchronous active-low reset; low forces high impedance |
| dbl_val | output | 1 | Double-rate clock value |
| dbl_oe | output | 1 | Double-rate output enable |
| base_val | output | NUM_BASE | Base-rate clock values |
| base_oe | output | NUM_BASE | Base-rate output enables |
| inv_val | output | 1 | Inverted base-rate clock value |
| inv_oe | output | 1 | Inverted base-rate output enable |
| half_val | output | 1 | Half-rate clock value |
| half_oe | output | 1 | Half-rate output enable |

## Verification
A counter that slips or a wrong tap offset shows up within the first five source edges after reset. It appears as a departure from the fixed start-up vector, or as a half-rate rise with no base or double rise on the same edge. A wrong clock selection or a missing halving stage leaves the edges aligned but changes the edge counts over a fixed window. So the bench counts edges in every combination of select inputs. An output register that drifts from its siblings breaks the equality of the base bits, or the complement of the inverted bit, on the very edge where it happens.

// File: rtl/clkdrv_pkg.sv
package clkdrv_pkg;

   // Next-state taps taken from the shared divider counter
   typedef struct packed {
      logic dbl;
      logic base;
      logic half;
   } clkdrv_taps_t;

   // Counter bits needed: three taps plus one for the optional prescale
   function automatic int unsigned clkdrv_cnt_width(input bit has_prediv);
      return has_prediv ? 4 : 3;
   endfunction

endpackage

// File: rtl/clkdrv_src_mux.sv
module clkdrv_src_mux (
   input  logic osc_clk,
   input  logic ref_a_clk,
   input  logic ref_b_clk,
   input  logic ref_pick,
   input  logic osc_en,
   output logic src_clk
);

   logic ref_clk;

   // Reference choice, then bypass of the oscillator for slow test clocks
   assign ref_clk = ref_pick ? ref_b_clk : ref_a_clk;
   assign src_clk = osc_en ? osc_clk : ref_clk;

endmodule

// File: rtl/clkdrv_div_core.sv
module clkdrv_div_core
   import clkdrv_pkg::*;
#(
   parameter bit HAS_PREDIV = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         div_sel,
   output clkdrv_taps_t taps_nxt
);

   localparam int unsigned CNT_W = clkdrv_cnt_width(HAS_PREDIV);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   // Down-counter: from zero every bit rises on the same edge, so each
   // lower tap rises whenever a higher tap does.
   assign cnt_nxt = cnt_q - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

   generate
      if (HAS_PREDIV) begin : g_prediv
         // Tap offset of one bit is the divide-by-two ahead of the outputs
         assign taps_nxt.dbl  = div_sel ? cnt_nxt[1] : cnt_nxt[0];
         assign taps_nxt.base = div_sel ? cnt_nxt[2] : cnt_nxt[1];
         assign taps_nxt.half = div_sel ? cnt_nxt[3] : cnt_nxt[2];
      end else begin : g_noprediv
         logic unused_sel;
         assign unused_sel    = div_sel;
         assign taps_nxt.dbl  = cnt_nxt[0];
         assign taps_nxt.base = cnt_nxt[1];
         assign taps_nxt.half = cnt_nxt[2];
      end
   endgenerate

endmodule

// File: rtl/clkdrv_out_regs.sv
module clkdrv_out_regs
   import clkdrv_pkg::*;
#(
   parameter int unsigned NUM_BASE = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  clkdrv_taps_t        taps_nxt,
   output logic                dbl_q,
   output logic [NUM_BASE-1:0] base_q,
   output logic                inv_q,
   output logic                half_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbl_q  <= 1'b0;
         half_q <= 1'b0;
         inv_q  <= 1'b1;
      end else begin
         dbl_q  <= taps_nxt.dbl;
         half_q <= taps_nxt.half;
         inv_q  <= ~taps_nxt.base;
      end
   end

   // One register per base output so each pin has its own flop
   generate
      for (genvar gi = 0; gi < NUM_BASE; gi++) begin : g_base
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) base_q[gi] <= 1'b0;
            else        base_q[gi] <= taps_nxt.base;
         end
      end
   endgenerate

endmodule

// File: rtl/clkdrv_outstage.sv
module clkdrv_outstage
   import clkdrv_pkg::*;
#(
   parameter int unsigned NUM_BASE   = 5,
   parameter bit          HAS_PREDIV = 1'b1
) (
   input  logic                osc_clk,
   input  logic                ref_a_clk,
   input  logic                ref_b_clk,
   input  logic                ref_pick,
   input  logic                osc_en,
   input  logic                div_sel,
   input  logic                rst_n,
   output logic                dbl_val,
   output logic                dbl_oe,
   output logic [NUM_BASE-1:0] base_val,
   output logic [NUM_BASE-1:0] base_oe,
   output logic                inv_val,
   output logic                inv_oe,
   output logic                half_val,
   output logic                half_oe
);

   generate
      if (NUM_BASE < 1 || NUM_BASE > 32) begin : g_bad_num_base
         $error("clkdrv_outstage: NUM_BASE must lie in 1..32");
      end
   endgenerate

   logic         src_clk;
   clkdrv_taps_t taps_nxt;

   clkdrv_src_mux i_src_mux (
      .osc_clk   (osc_clk),
      .ref_a_clk (ref_a_clk),
      .ref_b_clk (ref_b_clk),
      .ref_pick  (ref_pick),
      .osc_en    (osc_en),
      .src_clk   (src_clk)
   );

   clkdrv_div_core #(
      .HAS_PREDIV (HAS_PREDIV)
   ) i_div_core (
      .clk      (src_clk),
      .rst_n    (rst_n),
      .div_sel  (div_sel),
      .taps_nxt (taps_nxt)
   );

   clkdrv_out_regs #(
      .NUM_BASE (NUM_BASE)
   ) i_out_regs (
      .clk      (src_clk),
      .rst_n    (rst_n),
      .taps_nxt (taps_nxt),
      .dbl_q    (dbl_val),
      .base_q   (base_val),
      .inv_q    (inv_val),
      .half_q   (half_val)
   );

   // Reset low means every pin floats; pad ring builds the driver
   assign dbl_oe  = rst_n;
   assign base_oe = {NUM_BASE{rst_n}};
   assign inv_oe  = rst_n;
   assign half_oe = rst_n;

endmodule

// File: rtl/clkdrv_outstage_chk.sv
module clkdrv_outstage_chk #(
   parameter int unsigned NUM_BASE = 5
) (
   input logic                src_clk,
   input logic                rst_n,
   input logic                div_sel,
   input logic                dbl_val,
   input logic [NUM_BASE-1:0] base_val,
   input logic                inv_val,
   input logic                half_val
);

   // R5
   base_match_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
      base_val == {NUM_BASE{base_val[0]}});

   // R6
   inv_compl_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
      inv_val == ~base_val[0]);

   // R4
   dbl_toggle_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
      (!div_sel && $past(!div_sel) && $past(rst_n)) |-> (dbl_val != $past(dbl_val)));

   // R10
   half_align_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
      $rose(half_val) |-> ($rose(base_val[0]) && $rose(dbl_val)));

   // R10
   base_align_chk: assert property (@(posedge src_clk) disable iff (!rst_n)
      $rose(base_val[0]) |-> $rose(dbl_val));

endmodule

bind clkdrv_outstage clkdrv_outstage_chk #(.NUM_BASE(NUM_BASE)) i_chk (
   .src_clk  (src_clk),
   .rst_n    (rst_n),
   .div_sel  (div_sel),
   .dbl_val  (dbl_val),
   .base_val (base_val),
   .inv_val  (inv_val),
   .half_val (half_val)
);

// File: tb/test_clkdrv_outstage.sv
`timescale 1ns/100ps
module test_clkdrv_outstage;

   localparam int unsigned NB = 5;
   localparam real WIN_NS = 4800.0;

   logic osc_clk = 1'b0, ref_a_clk = 1'b0, ref_b_clk = 1'b0;
   logic ref_pick = 1'b0, osc_en = 1'b1, div_sel = 1'b0, rst_n = 1'b0;
   logic dbl_val, dbl_oe, inv_val, inv_oe, half_val, half_oe;
   logic [NB-1:0] base_val, base_oe;

   int n_checks = 0, n_errs = 0;
   int n_dbl, n_base, n_inv, n_half, n_mis;
   bit cnt_on = 1'b0;

   // 200 MHz oscillator; references edges land on oscillator rising edges
   always #2.5 osc_clk = ~osc_clk;
   initial begin #2.5; forever #20 ref_a_clk = ~ref_a_clk; end
   initial begin #2.5; forever #30 ref_b_clk = ~ref_b_clk; end

   clkdrv_outstage i_clkdrv_outstage (
      .osc_clk(osc_clk), .ref_a_clk(ref_a_clk), .ref_b_clk(ref_b_clk),
      .ref_pick(ref_pick), .osc_en(osc_en), .div_sel(div_sel), .rst_n(rst_n),
      .dbl_val(dbl_val), .dbl_oe(dbl_oe), .base_val(base_val), .base_oe(base_oe),
      .inv_val(inv_val), .inv_oe(inv_oe), .half_val(half_val), .half_oe(half_oe)
   );

   always @(posedge dbl_val)     if (cnt_on) n_dbl++;
   always @(posedge base_val[0]) if (cnt_on) n_base++;
   always @(posedge inv_val)     if (cnt_on) n_inv++;
   always @(posedge half_val)    if (cnt_on) n_half++;
   // R5 R6: sampled between edges while counting
   always @(negedge osc_clk)
      if (cnt_on && (base_val != {NB{base_val[0]}} || inv_val != ~base_val[0])) n_mis++;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit oe_in, input bit pick, input bit dv);
      @(negedge osc_clk);
      rst_n = 1'b0;
      osc_en = oe_in; ref_pick = pick; div_sel = dv;
      repeat (30) @(negedge osc_clk);
      rst_n = 1'b1;
   endtask

   task automatic test_reset_state();
      // R7: values cleared and pins floating while reset is held
      rst_n = 1'b0;
      repeat (4) @(negedge osc_clk);
      check({dbl_val, base_val[0], half_val, inv_val} == 4'b0001, "R7 reset values",
            {dbl_val, base_val[0], half_val, inv_val}, 4'b0001);
      check({dbl_oe, base_oe, inv_oe, half_oe} == '0, "R7 reset oe",
            {dbl_oe, base_oe, inv_oe, half_oe}, 0);
   endtask

   task automatic test_startup(input bit dv, input logic [2:0] exp_seq [5]);
      do_reset(1'b1, 1'b0, dv);
      for (int k = 0; k < 5; k++) begin
         @(negedge osc_clk);
         check({dbl_val, base_val[0], half_val} == exp_seq[k],
               dv ? "R9 R3 startup edge" : "R9 R10 startup edge",
               {dbl_val, base_val[0], half_val}, exp_seq[k]);
         check(inv_val == ~base_val[0], "R6 startup inverse", inv_val, ~base_val[0]);
      end
      // R8: enables high once out of reset
      check({dbl_oe, base_oe, inv_oe, half_oe} == {(NB+3){1'b1}}, "R8 enables",
            {dbl_oe, base_oe, inv_oe, half_oe}, {(NB+3){1'b1}});
   endtask

   task automatic test_rate(input bit oe_in, input bit pick, input bit dv,
                            input real src_ns, input string req);
      int exp_base;
      do_reset(oe_in, pick, dv);
      repeat (40) @(negedge osc_clk);
      n_dbl = 0; n_base = 0; n_inv = 0; n_half = 0; n_mis = 0;
      cnt_on = 1'b1;
      #(WIN_NS);
      cnt_on = 1'b0;
      exp_base = int'(WIN_NS / (src_ns * 4.0 * (dv ? 2.0 : 1.0)));
      check(n_base >= exp_base - 1 && n_base <= exp_base + 1, {req, " base count"}, n_base, exp_base);
      // R4: 2:1:0.5 ratio
      check(n_dbl >= 2*exp_base - 1 && n_dbl <= 2*exp_base + 1, "R4 double count", n_dbl, 2*exp_base);
      check(2*n_half >= exp_base - 2 && 2*n_half <= exp_base + 2, "R4 half count x2", 2*n_half, exp_base);
      check(n_inv >= exp_base - 1 && n_inv <= exp_base + 1, "R6 inverted count", n_inv, exp_base);
      check(n_mis == 0, "R5 R6 base equal and inverse", n_mis, 0);
   endtask

   task automatic test_async_reset();
      do_reset(1'b1, 1'b0, 1'b0);
      repeat (13) @(negedge osc_clk);
      #1.2;
      rst_n = 1'b0;
      #0.5;
      // R7: cleared without a clock edge
      check({dbl_val, base_val, half_val, inv_val} == {{(NB+2){1'b0}}, 1'b1}, "R7 async clear",
            {dbl_val, base_val, half_val, inv_val}, 1);
      check({dbl_oe, base_oe, inv_oe, half_oe} == '0, "R7 async float",
            {dbl_oe, base_oe, inv_oe, half_oe}, 0);
   endtask

   initial begin
      logic [2:0] seq0 [5];
      logic [2:0] seq1 [5];
      seq0 = '{3'b111, 3'b011, 3'b101, 3'b001, 3'b110};
      seq1 = '{3'b111, 3'b111, 3'b011, 3'b011, 3'b101};
      test_reset_state();
      test_startup(1'b0, seq0);
      test_startup(1'b1, seq1);
      test_rate(1'b1, 1'b0, 1'b0, 5.0,  "R2 R4 osc");
      test_rate(1'b1, 1'b1, 1'b0, 5.0,  "R2 osc pick ignored");
      test_rate(1'b1, 1'b0, 1'b1, 5.0,  "R3 osc halved");
      test_rate(1'b0, 1'b0, 1'b0, 40.0, "R1 R2 bypass ref_a");
      test_rate(1'b0, 1'b1, 1'b0, 60.0, "R1 bypass ref_b");
      test_rate(1'b0, 1'b1, 1'b1, 60.0, "R3 bypass ref_b halved");
      test_async_reset();
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      #500000;
      n_checks++; n_errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule